// File: doc/BRIEF.md
# Fixed-Pattern Ring Sequencer

This block is a Moore state machine that steps through a ring of five states and shows a fixed 2-bit value for each one, so that the output repeats the pattern 3, 2, 3, 1, 2 without end. The pattern holds the same value in more than one place. For this reason the state code and the output value are kept apart: a 3-bit register holds the position in the ring, and a separate decoder turns that position into the output value.

Only five of the eight 3-bit codes are ring positions. If the register ever holds one of the other three codes, the output shows 0 for that cycle and the machine goes back to the start position on the next clock. The present state is brought out as a port. A load port meant only for test can write any code, legal or not, into the state register, so that recovery from a bad code can be driven and watched at the pins. In normal use the load enable is tied low.

Top module: `seq_ring_counter`

## Requirements
- R1: While rst_ni is low, state_o is 0 and value_o is 3. The reset takes effect at once and does not wait for a clock edge. It also overrides any load request.
- R2: When rst_ni is high and load_en_i is low, each rising edge of clk_i moves state_o along the ring 0→1→2→3→4→0.
- R3: value_o depends only on state_o. State code 0 gives 3, code 1 gives 2, code 2 gives 3, code 3 gives 1 and code 4 gives 2.
- R4: When state_o holds one of the unused codes 5, 6 or 7, value_o is 0.
- R5: From an unused code (5, 6 or 7), the next rising edge puts state_o back to 0 when no load is requested.
- R6: A rising edge with load_en_i high writes load_state_i into the state register. This replaces the normal step for that edge.
- R7: Once reset is released and no load is requested, value_o follows 3,2,3,1,2 in a repeating loop, one value per clock, with no gaps and no slips over many periods.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock, rising-edge active |
| rst_ni | input | 1 | Asynchronous reset, active low |
| load_en_i | input | 1 | Test-only: load state register on next edge |
| load_state_i | input | 3 | Test-only: state code to load |
| value_o | output | 2 | Output value for the present state |
| state_o | output | 3 | Present state code |

## Verification
The bench runs the ring for many periods. A machine that decodes the output straight from a binary count, or that merges the two positions that both give 3 or both give 2, shows a different value at some step of the pattern. Each unused code is forced in through the load port. A decoder that lets an unused code alias onto a ring value would show something other than 0 in that cycle, and a next-state function that only wraps at code 4 would leave the machine stuck or let it wander instead of going back to 0. Two priority cases are also checked: a load must win over the normal step, and reset must win over a pending load and must act before any clock edge.

// File: rtl/seq_ring_pkg.sv
package seq_ring_pkg;
  localparam int STATE_W  = 3;
  localparam int VAL_W    = 2;
  localparam int RING_LEN = 5;

  typedef logic [STATE_W-1:0] state_t;
  typedef logic [VAL_W-1:0]   val_t;

  // value shown at each ring position; anything outside the ring shows 0
  function automatic val_t ring_value(int unsigned pos);
    case (pos)
      0:       ring_value = val_t'(3);
      1:       ring_value = val_t'(2);
      2:       ring_value = val_t'(3);
      3:       ring_value = val_t'(1);
      4:       ring_value = val_t'(2);
      default: ring_value = val_t'(0);
    endcase
  endfunction
endpackage

// File: rtl/seq_next_logic.sv
module seq_next_logic #(
  parameter int STATE_W  = seq_ring_pkg::STATE_W,
  parameter int RING_LEN = seq_ring_pkg::RING_LEN
) (
  input  logic [STATE_W-1:0] ps_i,
  input  logic               load_en_i,
  input  logic [STATE_W-1:0] load_state_i,
  output logic [STATE_W-1:0] ns_o
);
  localparam logic [STATE_W-1:0] LAST_POS = STATE_W'(RING_LEN - 1);

  // codes at or past LAST_POS fall back to the start position
  always_comb begin
    if (load_en_i)            ns_o = load_state_i;
    else if (ps_i < LAST_POS) ns_o = ps_i + STATE_W'(1);
    else                      ns_o = '0;
  end
endmodule

// File: rtl/seq_state_reg.sv
module seq_state_reg #(
  parameter int STATE_W = seq_ring_pkg::STATE_W
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [STATE_W-1:0] d_i,
  output logic [STATE_W-1:0] q_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) q_o <= '0;
    else         q_o <= d_i;
  end
endmodule

// File: rtl/seq_out_decode.sv
module seq_out_decode #(
  parameter int STATE_W  = seq_ring_pkg::STATE_W,
  parameter int VAL_W    = seq_ring_pkg::VAL_W,
  parameter int RING_LEN = seq_ring_pkg::RING_LEN
) (
  input  logic [STATE_W-1:0] ps_i,
  output logic [VAL_W-1:0]   val_o
);
  logic [RING_LEN-1:0] hit;
  logic [VAL_W-1:0]    term [RING_LEN];

  for (genvar k = 0; k < RING_LEN; k++) begin : g_pos
    assign hit[k]  = (ps_i == STATE_W'(k));
    assign term[k] = hit[k] ? VAL_W'(seq_ring_pkg::ring_value(k)) : '0;
  end

  // one-hot OR: codes outside the ring match nothing and give 0
  always_comb begin
    val_o = '0;
    for (int k = 0; k < RING_LEN; k++) val_o = val_o | term[k];
  end
endmodule

// File: rtl/seq_ring_counter.sv
module seq_ring_counter #(
  parameter int STATE_W  = seq_ring_pkg::STATE_W,
  parameter int VAL_W    = seq_ring_pkg::VAL_W,
  parameter int RING_LEN = seq_ring_pkg::RING_LEN
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               load_en_i,
  input  logic [STATE_W-1:0] load_state_i,
  output logic [VAL_W-1:0]   value_o,
  output logic [STATE_W-1:0] state_o
);
  logic [STATE_W-1:0] ps, ns;

  seq_next_logic #(.STATE_W(STATE_W), .RING_LEN(RING_LEN)) u_next (
    .ps_i(ps), .load_en_i(load_en_i), .load_state_i(load_state_i), .ns_o(ns)
  );

  seq_state_reg #(.STATE_W(STATE_W)) u_reg (
    .clk_i(clk_i), .rst_ni(rst_ni), .d_i(ns), .q_o(ps)
  );

  seq_out_decode #(.STATE_W(STATE_W), .VAL_W(VAL_W), .RING_LEN(RING_LEN)) u_dec (
    .ps_i(ps), .val_o(value_o)
  );

  assign state_o = ps;
endmodule

// File: rtl/seq_ring_checker.sv
module seq_ring_checker (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       load_en_i,
  input logic [2:0] load_state_i,
  input logic [1:0] value_o,
  input logic [2:0] state_o
);
  a_r2_step: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!load_en_i && state_o < 3'd4) |=> state_o == $past(state_o) + 3'd1);
  a_r2_wrap: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!load_en_i && state_o == 3'd4) |=> state_o == 3'd0);
  a_r5_recover: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!load_en_i && state_o > 3'd4) |=> state_o == 3'd0);
  a_r6_load: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_en_i |=> state_o == $past(load_state_i));
  a_r4_unused_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    state_o > 3'd4 |-> value_o == 2'd0);
  a_r3_pos0: assert property (@(posedge clk_i) disable iff (!rst_ni)
    state_o == 3'd0 |-> value_o == 2'd3);
  a_r3_pos3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    state_o == 3'd3 |-> value_o == 2'd1);
  a_r3_pos1_4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_o == 3'd1 || state_o == 3'd4) |-> value_o == 2'd2);
endmodule

bind seq_ring_counter seq_ring_checker u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .load_en_i(load_en_i),
  .load_state_i(load_state_i), .value_o(value_o), .state_o(state_o)
);

// File: tb/seq_ring_counter_tb.sv
module seq_ring_counter_tb;
  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       load_en_i = 1'b0;
  logic [2:0] load_state_i = '0;
  logic [1:0] value_o;
  logic [2:0] state_o;
  int n_chk = 0;
  int n_fail = 0;

  seq_ring_counter u_dut (
    .clk_i(clk_i), .rst_ni(rst_ni), .load_en_i(load_en_i),
    .load_state_i(load_state_i), .value_o(value_o), .state_o(state_o)
  );

  always #2 clk_i = ~clk_i;

  function automatic int exp_val(int s);
    case (s)
      0: return 3; 1: return 2; 2: return 3; 3: return 1; 4: return 2;
      default: return 0;
    endcase
  endfunction

  task automatic chk(string req, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic t_reset;
    @(negedge clk_i);
    rst_ni = 1'b0;
    #1;
    chk("R1 state in reset", state_o, 0);
    chk("R1 value in reset", value_o, 3);
    @(negedge clk_i);
    chk("R1 state held", state_o, 0);
    rst_ni = 1'b1;
  endtask

  task automatic t_ring(int periods);
    for (int i = 0; i < periods * 5; i++) begin
      chk("R2 ring position", state_o, i % 5);
      chk("R7 pattern value", value_o, exp_val(i % 5));
      @(negedge clk_i);
    end
  endtask

  task automatic t_unused(int code);
    load_en_i = 1'b1;
    load_state_i = 3'(code);
    @(negedge clk_i);
    load_en_i = 1'b0;
    chk("R6 unused code loaded", state_o, code);
    chk("R4 unused value zero", value_o, 0);
    @(negedge clk_i);
    chk("R5 back to start", state_o, 0);
    chk("R3 start value", value_o, 3);
  endtask

  task automatic t_load_legal;
    // state now 0; load 3 instead of stepping to 1
    load_en_i = 1'b1;
    load_state_i = 3'd3;
    @(negedge clk_i);
    load_en_i = 1'b0;
    chk("R6 load beats step", state_o, 3);
    chk("R3 value at 3", value_o, 1);
    @(negedge clk_i);
    chk("R2 step after load", state_o, 4);
    chk("R3 value at 4", value_o, 2);
    @(negedge clk_i);
    chk("R2 wrap to 0", state_o, 0);
  endtask

  task automatic t_reset_over_load;
    load_en_i = 1'b1;
    load_state_i = 3'd2;
    @(negedge clk_i);
    chk("R6 load 2", state_o, 2);
    rst_ni = 1'b0;
    #1;
    chk("R1 async reset mid-run", state_o, 0);
    @(negedge clk_i);
    chk("R1 reset beats load", state_o, 0);
    chk("R1 reset value", value_o, 3);
    load_en_i = 1'b0;
    rst_ni = 1'b1;
  endtask

  initial begin
    #800000;
    n_fail++;
    n_chk++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    t_reset();
    t_ring(12);
    for (int c = 5; c < 8; c++) t_unused(c);
    t_load_legal();
    t_reset_over_load();
    t_ring(3);
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule